// File: doc/BRIEF.md
# Three-Sweep Safe Softmax Engine

This block turns a vector of N signed fixed-point scores into a probability vector. Scores arrive one per handshake and are held in a local buffer. Three sweeps over that buffer follow. The first finds the largest score. The second sums the exponentials of each score minus that largest value. A short reciprocal step then computes one over the sum with a bit-serial divider. The third sweep streams out each exponential scaled by that reciprocal, in the same order in which the scores arrived.

Every exponent argument is the difference between a score and the vector maximum, so it is never positive and every exponential lies in (0, 1]. The exponential is computed as a power of two, split into an integer shift and a quadratic fractional term. The sum therefore cannot overflow for any input. A consumer drains the result through a valid/ready port, and a last flag marks the end of the vector. After the last result is taken, the block accepts the next vector.

Top module: `safe_softmax3`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Scores are taken on cycles where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the cycle after the N-th score is taken until the vector's last result has been handed over.
- R3: `in_data` is two's complement with FRAC fraction bits. Each `out_data` is unsigned with OW-1 fraction bits, so 1.0 is 2^(OW-1). Each result is within 330 LSB (about 1 %) of exp(x_i - max)/sum_j exp(x_j - max) at the default parameters.
- R4: Results leave in the order in which the scores arrived.
- R5: `out_last` is 1 with the N-th result of a vector and 0 with every other result.
- R6: If all N scores are equal and N is a power of two, every result is exactly 2^(OW-1)/N.
- R7: If one score exceeds every other score by at least 12.0, its result is exactly 2^(OW-1) and all other results are 0. This holds even at the extremes of the input range.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R9: No result exceeds 2^(OW-1).
- R10: The running maximum restarts from the most negative value for each vector. A vector of small scores that follows a vector of large scores gets the same results as it would straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Score present on `in_data` |
| in_ready | output | 1 | Block can take a score |
| in_data | input | DW | Signed fixed-point score, FRAC fraction bits |
| out_valid | output | 1 | Result present on `out_data` |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | OW | Probability, OW-1 fraction bits |
| out_last | output | 1 | Marks the N-th result |

## Verification
The bench checks uniform vectors, where a wrong reciprocal scale or a wrong exponential at zero would break the exact 1/N value. It checks one dominant score at the limits of the input range, where a design with a narrow difference or product would wrap and give non-zero tails or a wrong peak. A vector of small scores follows one of large scores, so a running maximum that is not restarted would drive every result towards zero. A stall on the output catches results that advance without a handshake. Misplaced last flags and out-of-order results show up as mismatches against the per-element expected values.

// File: rtl/safe_softmax3.sv
module safe_softmax3 #(
  parameter int N    = 8,
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int OW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OW-1:0]        out_data,
  output logic                 out_last
);
  localparam int CW  = (N > 1) ? $clog2(N) : 1;
  localparam int EF  = OW - 1;
  localparam int EW  = OW;
  localparam int SW  = EW + CW + 1;
  localparam int K   = 2 * EF + 2;
  localparam int RW  = EF + 3;
  localparam int DCW = $clog2(K + 1);
  localparam int NW  = DW + 2 - FRAC;
  localparam int PW  = DW + 17;
  localparam logic [15:0] LOG2E = 16'd47274;
  localparam logic [15:0] CA    = 16'd43025;
  localparam logic [15:0] CB    = 16'd22511;
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [2:0] {IDLE, LOAD, MAX, SUM, RECIP, NORM, DONE} st_t;
  st_t st;

  logic signed [DW-1:0] mem [N];
  logic signed [DW-1:0] mx, rd;
  logic [CW-1:0]  cnt;
  logic [SW-1:0]  sum, rem;
  logic [RW-1:0]  rcp;
  logic [DCW-1:0] dcnt;
  logic           at_end;

  assign rd     = mem[cnt];
  assign at_end = (cnt == CW'(N - 1));

  logic [DW:0]    tdiff;
  logic [PW-1:0]  prod;
  logic [NW-1:0]  nint;
  logic [15:0]    frac;
  logic [16:0]    g, inner;
  logic [32:0]    bg;
  logic [33:0]    gi;
  logic [17:0]    pw2, shifted;
  logic [5:0]     sh;
  logic [EW-1:0]  ex;

  assign tdiff = {mx[DW-1], mx} - {rd[DW-1], rd};
  assign prod  = {16'b0, tdiff} * {{(DW+1){1'b0}}, LOG2E};
  assign nint  = prod[PW-1:FRAC+15];
  assign frac  = prod[FRAC+14:FRAC-1];
  assign g     = 17'h10000 - {1'b0, frac};
  assign bg    = {17'b0, CB} * {16'b0, g};
  assign inner = {1'b0, CA} + bg[32:16];
  assign gi    = {17'b0, g} * {17'b0, inner};
  assign pw2   = 18'h10000 + gi[33:16];
  assign sh    = 6'(nint[4:0]) + 6'(17 - EF);
  assign shifted = pw2 >> sh;
  assign ex    = (nint > NW'(20)) ? '0 : shifted[EW-1:0];

  logic [SW:0]       trial;
  logic              ge;
  logic [EW+RW-1:0]  scaled;

  assign trial  = {rem, (dcnt == '0)};
  assign ge     = trial >= {1'b0, sum};
  assign scaled = {{RW{1'b0}}, ex} * {{EW{1'b0}}, rcp};

  assign in_ready  = (st == IDLE) || (st == LOAD);
  assign out_valid = (st == NORM);
  assign out_last  = (st == NORM) && at_end;
  assign out_data  = (st == NORM) ? scaled[EF+2+OW-1:EF+2] : '0;

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) mem[cnt] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      mx   <= MINV;
      sum  <= '0;
      rem  <= '0;
      rcp  <= '0;
      dcnt <= '0;
    end else begin
      unique case (st)
        IDLE, LOAD: if (in_valid) begin
          if (at_end) begin
            st  <= MAX;
            cnt <= '0;
            mx  <= MINV;
          end else begin
            st  <= LOAD;
            cnt <= cnt + 1'b1;
          end
        end
        MAX: begin
          mx <= (rd > mx) ? rd : mx;
          if (at_end) begin
            st  <= SUM;
            cnt <= '0;
            sum <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SUM: begin
          sum <= sum + SW'(ex);
          if (at_end) begin
            st   <= RECIP;
            cnt  <= '0;
            dcnt <= '0;
            rem  <= '0;
            rcp  <= '0;
          end else cnt <= cnt + 1'b1;
        end
        RECIP: begin
          rem  <= ge ? SW'(trial - {1'b0, sum}) : trial[SW-1:0];
          rcp  <= {rcp[RW-2:0], ge};
          dcnt <= dcnt + 1'b1;
          if (dcnt == DCW'(K)) st <= NORM;
        end
        NORM: if (out_ready) begin
          if (at_end) begin
            st  <= DONE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        DONE: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module safe_softmax3_chk #(
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          out_last
);
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= (OW'(1) << (OW - 1))));

  assert_end_of_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind safe_softmax3 safe_softmax3_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/test_safe_softmax3.sv
`timescale 1ns/1ps
module test_safe_softmax3;
  localparam int N = 8, DW = 16, FRAC = 8, OW = 16, NV = 5, TOL = 330;
  localparam int ONE = 1 << (OW - 1);
  localparam logic signed [DW-1:0] VEC [0:NV-1][0:N-1] = '{
    '{16'sd0, 16'sd256, 16'sd512, 16'sd768, 16'sd1024, 16'sd1280, 16'sd1536, 16'sd1792},
    '{-16'sd256, 16'sd0, 16'sd256, -16'sd512, 16'sd128, -16'sd128, 16'sd64, -16'sd64},
    '{16'sd1000, -16'sd2000, 16'sd300, 16'sd300, -16'sd50, 16'sd700, -16'sd1500, 16'sd20},
    '{16'sd12345, -16'sd3210, 16'sd11000, 16'sd12000, -16'sd999, 16'sd12300, 16'sd8000, 16'sd12345},
    '{-16'sd20000, -16'sd20100, -16'sd19900, -16'sd20050, -16'sd20000, -16'sd19950, -16'sd20200, -16'sd20000}
  };

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 1;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [OW-1:0] out_data;
  int checks = 0, errors = 0, cyc = 0;
  logic signed [DW-1:0] cur [N];
  int got [N];

  always #2.5 clk = ~clk;

  safe_softmax3 #(.N(N), .DW(DW), .FRAC(FRAC), .OW(OW)) i_safe_softmax3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = cur[i];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0;
    check(!in_ready, "R2 in_ready after load", int'(in_ready), 0);
  endtask

  task automatic collect();
    for (int i = 0; i < N; i++) begin
      while (!out_valid) @(negedge clk);
      got[i] = int'(out_data);
      check(out_last == (i == N - 1), "R5 last flag", int'(out_last), int'(i == N - 1));
      check(!in_ready, "R2 in_ready while draining", int'(in_ready), 0);
      @(negedge clk);
    end
    @(negedge clk);
    check(in_ready && !out_valid, "R10 ready for next vector", int'(in_ready), 1);
  endtask

  task automatic check_ref(input string req);
    real mx, den, ideal;
    mx = -1.0e9; den = 0.0;
    for (int i = 0; i < N; i++) if (real'(cur[i]) / 256.0 > mx) mx = real'(cur[i]) / 256.0;
    for (int i = 0; i < N; i++) den += $exp(real'(cur[i]) / 256.0 - mx);
    for (int i = 0; i < N; i++) begin
      int e, d;
      ideal = $exp(real'(cur[i]) / 256.0 - mx) / den * real'(ONE);
      e = $rtoi(ideal + 0.5);
      d = got[i] - e;
      check(d <= TOL && d >= -TOL, req, got[i], e);
      check(got[i] <= ONE, "R9 bound", got[i], ONE);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    #1;
    check(in_ready && !out_valid, "R1 reset state", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && !out_valid, "R1 after reset", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < N; i++) cur[i] = VEC[v][i];
      send();
      collect();
      check_ref("R3 R4 value and order");
    end

    for (int i = 0; i < N; i++) cur[i] = 16'sd777;
    send(); collect();
    for (int i = 0; i < N; i++) check(got[i] == ONE / N, "R6 uniform", got[i], ONE / N);
    for (int i = 0; i < N; i++) cur[i] = 16'sd32767;
    send(); collect();
    for (int i = 0; i < N; i++) check(got[i] == ONE / N, "R6 uniform at top", got[i], ONE / N);

    for (int i = 0; i < N; i++) cur[i] = (i == 5) ? 16'sd32767 : -16'sd32768;
    send(); collect();
    for (int i = 0; i < N; i++)
      check(got[i] == ((i == 5) ? ONE : 0), "R7 dominant extreme", got[i], (i == 5) ? ONE : 0);
    for (int i = 0; i < N; i++) cur[i] = (i == 0) ? 16'sd3072 : 16'sd0;
    send(); collect();
    for (int i = 0; i < N; i++)
      check(got[i] == ((i == 0) ? ONE : 0), "R7 dominant by 12", got[i], (i == 0) ? ONE : 0);

    for (int i = 0; i < N; i++) cur[i] = 16'sd30000 - 16'(i * 100);
    send(); collect(); check_ref("R3 large vector");
    for (int i = 0; i < N; i++) cur[i] = VEC[1][i];
    send(); collect(); check_ref("R10 small after large");

    out_ready = 0;
    for (int i = 0; i < N; i++) cur[i] = VEC[0][i];
    send();
    while (!out_valid) @(negedge clk);
    held = int'(out_data);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid && int'(out_data) == held && !out_last, "R8 stall hold", int'(out_data), held);
    end
    out_ready = 1;
    collect();
    check(got[0] == held, "R8 held value taken", got[0], held);
    check_ref("R4 after stall");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule